// File: doc/BRIEF.md
# Endian-Selectable Word Data Memory

This block is a small byte-addressed data store that serves whole 32-bit words to a load/store processor. Each request supplies a base value, a signed 16-bit displacement, a load-or-store command and, for a store, the word to write. The block adds the displacement to the base, checks that the resulting address is word aligned, and then moves four consecutive bytes between the store and the request.

The order in which the four bytes of a word are laid into memory follows a mode input that is sampled with every request. With the mode set to big-endian, the most significant byte lands at the lowest address. With it set to little-endian, the least significant byte lands there. Bytes written under one mode and read under the other come back reversed. Loads return their word in a register one cycle after the request. A misaligned request writes nothing, returns zero on a load, and raises an error flag for one cycle.

Top module: `endian_word_mem`

## Requirements
- R1: After reset, loadWord and misalignErr are 0, and every byte of storage reads as zero.
- R2: The effective address is baseAddr plus offsetImm sign-extended to 32 bits, so offsets from -32768 to 32767 are reached.
- R3: With bigEndianSel=1, a store of word W at aligned address A puts W[31:24] at A, W[23:16] at A+1, W[15:8] at A+2 and W[7:0] at A+3, and a load reads the bytes back in that same placement.
- R4: With bigEndianSel=0, a store of word W at aligned address A puts W[7:0] at A, W[15:8] at A+1, W[23:16] at A+2 and W[31:24] at A+3, and a load reads the bytes back in that same placement.
- R5: Bytes stored under one value of bigEndianSel and loaded under the other give the byte-reversed word (0x01020304 reads back as 0x04030201).
- R6: When the two low bits of the effective address are not both zero, misalignErr is 1 in the cycle after the request, a store changes no byte, and a load sets loadWord to 0.
- R7: Only the low log2(DEPTH) bits of the effective address select a byte (DEPTH=1024 by default), so address A+DEPTH reaches the same byte as A.
- R8: loadWord takes its new value on the clock edge that accepts a load request and keeps its value through idle cycles and stores.
- R9: misalignErr is 0 in the cycle after an idle cycle or an aligned request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is presented this cycle |
| reqStore | input | 1 | 1 = store, 0 = load |
| baseAddr | input | 32 | Base value of the address |
| offsetImm | input | 16 | Signed displacement added to the base |
| storeWord | input | 32 | Word written by a store |
| bigEndianSel | input | 1 | 1 = big-endian byte order, 0 = little-endian |
| loadWord | output | 32 | Registered result of the last load |
| misalignErr | output | 1 | One-cycle flag for a misaligned request |

## Verification
A wrong lane mapping or a corrupted byte stays silent in storage until the word is loaded. It then shows as a wrong loadWord one cycle after that load, so the bench keeps a byte-level image of memory and loads back areas it has written under both modes. A fault in the adder or in the wrap shows as a load that returns bytes from the wrong place. A bad alignment decision shows one cycle after the request, either as a wrong misalignErr or as a store that leaks into memory, and a later aligned load of the neighbouring word reveals the leak.

// File: rtl/endian_mem_pkg.sv
package endian_mem_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned LANES   = WORD_W / BYTE_W;
  localparam int unsigned OFF_W   = 16;

  // Strobes from control to datapath for one accepted request.
  typedef struct packed {
    logic wrEn;      // aligned store
    logic rdEn;      // aligned load
    logic zeroLoad;  // misaligned load, result forced to zero
    logic bigEnd;    // byte order for this access
  } strobe_t;

  // Bit position of the byte that sits at offset pos inside a word.
  function automatic int unsigned laneBit(input int unsigned pos, input logic bigEnd);
    return bigEnd ? (LANES - 1 - pos) * BYTE_W : pos * BYTE_W;
  endfunction

endpackage

// File: rtl/endian_mem_ctrl.sv
module endian_mem_ctrl
  import endian_mem_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned IDXW = AW - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqStore,
  input  logic [WORD_W-1:0] baseAddr,
  input  logic [OFF_W-1:0]  offsetImm,
  input  logic              bigEndianSel,
  output strobe_t           strb,
  output logic [IDXW-1:0]   wordIdx,
  output logic              misalignErr
);

  logic [WORD_W-1:0] offsetExt;
  logic [WORD_W-1:0] effAddr;
  logic              badAlign;
  logic [WORD_W-AW-1:0] unusedHi;

  always_comb begin
    offsetExt = {{(WORD_W - OFF_W){offsetImm[OFF_W-1]}}, offsetImm};
    effAddr   = baseAddr + offsetExt;
    badAlign  = effAddr[1:0] != 2'b00;
    wordIdx   = effAddr[AW-1:2];
    unusedHi  = effAddr[WORD_W-1:AW];
  end

  always_comb begin
    strb          = '0;
    strb.bigEnd   = bigEndianSel;
    if (reqValid) begin
      strb.wrEn     = reqStore && !badAlign;
      strb.rdEn     = !reqStore && !badAlign;
      strb.zeroLoad = !reqStore && badAlign;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) misalignErr <= 1'b0;
    else       misalignErr <= reqValid && badAlign;
  end

  // R2: the distance from base to effective address carries the offset's sign
  p_sign_ext_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> ((effAddr - baseAddr) == {{16{offsetImm[15]}}, offsetImm}));

  // R6: a misaligned request raises the flag on the next cycle
  p_err_follows_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (effAddr[1:0] != 2'b00)) |=> misalignErr);

  // R9: no flag after an idle cycle
  p_err_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !misalignErr);

  // R6: at most one strobe per request
  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrEn, strb.rdEn, strb.zeroLoad}));

endmodule

// File: rtl/endian_mem_dpath.sv
module endian_mem_dpath
  import endian_mem_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned IDXW = AW - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [IDXW-1:0]   wordIdx,
  input  logic [WORD_W-1:0] storeWord,
  output logic [WORD_W-1:0] loadWord
);

  logic [BYTE_W-1:0] memBytes [DEPTH];
  logic [BYTE_W-1:0] wrByte   [LANES];
  logic [WORD_W-1:0] rdWord;

  // Per byte position: pick the source lane for writes, place the lane for reads.
  for (genvar p = 0; p < LANES; p++) begin : g_lane
    localparam int unsigned BE_BIT = laneBit(p, 1'b1);
    localparam int unsigned LE_BIT = laneBit(p, 1'b0);
    logic [AW-1:0]     byteAddr;
    logic [BYTE_W-1:0] rdByte;

    assign byteAddr = {wordIdx, 2'(p)};
    assign rdByte   = memBytes[byteAddr];
    assign wrByte[p] = strb.bigEnd ? storeWord[BE_BIT +: BYTE_W]
                                   : storeWord[LE_BIT +: BYTE_W];
    assign rdWord[BE_BIT +: BYTE_W] = strb.bigEnd ? rdByte
                                                  : memBytes[{wordIdx, 2'(LANES - 1 - p)}];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) memBytes[i] <= '0;
    end else if (strb.wrEn) begin
      for (int p = 0; p < LANES; p++) memBytes[{wordIdx, 2'(p)}] <= wrByte[p];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              loadWord <= '0;
    else if (strb.zeroLoad) loadWord <= '0;
    else if (strb.rdEn)     loadWord <= rdWord;
  end

  // R6: a misaligned load yields zero
  p_zero_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.zeroLoad |=> (loadWord == '0));

  // R8: the result holds when no load is accepted
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.rdEn || strb.zeroLoad) |=> $stable(loadWord));

  // R6: storage is untouched unless an aligned store is strobed (word zero sampled)
  p_mem_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wrEn) |=> $stable(memBytes[0]));

endmodule

// File: rtl/endian_word_mem.sv
module endian_word_mem
  import endian_mem_pkg::*;
#(
  parameter int unsigned DEPTH = 1024
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqStore,
  input  logic [31:0] baseAddr,
  input  logic [15:0] offsetImm,
  input  logic [31:0] storeWord,
  input  logic        bigEndianSel,
  output logic [31:0] loadWord,
  output logic        misalignErr
);

  localparam int unsigned AW   = $clog2(DEPTH);
  localparam int unsigned IDXW = AW - 2;

  strobe_t         strb;
  logic [IDXW-1:0] wordIdx;

  endian_mem_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqStore     (reqStore),
    .baseAddr     (baseAddr),
    .offsetImm    (offsetImm),
    .bigEndianSel (bigEndianSel),
    .strb         (strb),
    .wordIdx      (wordIdx),
    .misalignErr  (misalignErr)
  );

  endian_mem_dpath #(.DEPTH(DEPTH)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wordIdx   (wordIdx),
    .storeWord (storeWord),
    .loadWord  (loadWord)
  );

endmodule

// File: tb/tb_endian_word_mem.sv
`timescale 1ns/1ps
module tb_endian_word_mem;

  localparam int DEPTH = 1024;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqStore, bigEndianSel;
  logic [31:0] baseAddr, storeWord;
  logic [15:0] offsetImm;
  logic [31:0] loadWord;
  logic        misalignErr;

  int nChecks = 0;
  int nErrs   = 0;
  logic [7:0]  model [DEPTH];
  logic [31:0] lastLoad;

  always #5 clk = ~clk;

  endian_word_mem #(.DEPTH(DEPTH)) dut (.*);

  function automatic logic [31:0] effOf(input logic [31:0] b, input logic [15:0] o);
    return b + {{16{o[15]}}, o};
  endfunction

  function automatic logic [31:0] modelRead(input logic [31:0] ea, input logic be);
    logic [31:0] w;
    for (int p = 0; p < 4; p++) begin
      if (be) w[(3-p)*8 +: 8] = model[(ea + p) % DEPTH];
      else    w[p*8 +: 8]     = model[(ea + p) % DEPTH];
    end
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErrs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at negedge, check at the following negedge.
  task automatic doOp(input bit st, input logic [31:0] b, input logic [15:0] o,
                      input logic [31:0] d, input bit be, input string req);
    logic [31:0] ea;
    logic        bad;
    logic [31:0] expLoad;
    ea  = effOf(b, o);
    bad = ea[1:0] != 2'b00;
    reqValid = 1'b1; reqStore = st; baseAddr = b; offsetImm = o;
    storeWord = d; bigEndianSel = be;
    expLoad = lastLoad;
    if (!st) expLoad = bad ? 32'h0 : modelRead(ea, be);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    if (st && !bad) begin
      for (int p = 0; p < 4; p++)
        model[(ea + p) % DEPTH] = be ? d[(3-p)*8 +: 8] : d[p*8 +: 8];
    end
    lastLoad = expLoad;
    check(misalignErr == bad, {req, " R6/R9 flag"}, {31'b0, misalignErr}, {31'b0, bad});
    check(loadWord == expLoad, {req, " R8 load"}, loadWord, expLoad);
  endtask

  task automatic idle(input string req);
    @(posedge clk);
    @(negedge clk);
    check(misalignErr == 1'b0, {req, " R9 idle flag"}, {31'b0, misalignErr}, 32'h0);
    check(loadWord == lastLoad, {req, " R8 hold"}, loadWord, lastLoad);
  endtask

  initial begin
    #2_000_000;
    nErrs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    lastLoad = 32'h0;
    rstN = 1'b0; reqValid = 1'b0; reqStore = 1'b0; bigEndianSel = 1'b1;
    baseAddr = '0; offsetImm = '0; storeWord = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check(loadWord == 32'h0, "R1 reset load", loadWord, 32'h0);
    check(misalignErr == 1'b0, "R1 reset flag", {31'b0, misalignErr}, 32'h0);
    doOp(1'b0, 32'd100, 16'd0, '0, 1'b1, "R1 empty memory");
    doOp(1'b0, 32'd1020, 16'd0, '0, 1'b0, "R1 empty memory top");

    // R3 big-endian placement, R2 positive offset
    doOp(1'b1, 32'd96, 16'd4, 32'h01020304, 1'b1, "R3 store");
    doOp(1'b0, 32'd100, 16'd0, '0, 1'b1, "R3 load");
    check(loadWord == 32'h01020304, "R3 literal", loadWord, 32'h01020304);
    // R5 reversed under the other mode
    doOp(1'b0, 32'd100, 16'd0, '0, 1'b0, "R5 load");
    check(loadWord == 32'h04030201, "R5 literal", loadWord, 32'h04030201);

    // R4 little-endian placement with R2 negative offset
    doOp(1'b1, 32'd208, 16'hFFF8, 32'hA1B2C3D4, 1'b0, "R4 store");
    doOp(1'b0, 32'd200, 16'd0, '0, 1'b1, "R4 load");
    check(loadWord == 32'hD4C3B2A1, "R4/R5 literal", loadWord, 32'hD4C3B2A1);
    doOp(1'b0, 32'd0, 16'd200, '0, 1'b0, "R2 load");
    check(loadWord == 32'hA1B2C3D4, "R2 literal", loadWord, 32'hA1B2C3D4);

    // R7 wrap
    doOp(1'b0, 32'd100 + DEPTH, 16'd0, '0, 1'b1, "R7 wrap load");
    check(loadWord == 32'h01020304, "R7 literal", loadWord, 32'h01020304);
    doOp(1'b1, 32'd4, 16'hFFF8, 32'hCAFEF00D, 1'b1, "R7 neg wrap store");
    doOp(1'b0, 32'd1020, 16'd0, '0, 1'b1, "R7 neg wrap load");
    check(loadWord == 32'hCAFEF00D, "R7 wrap literal", loadWord, 32'hCAFEF00D);

    // R6 misaligned store leaves memory, misaligned load gives zero
    doOp(1'b1, 32'd101, 16'd0, 32'hFFFFFFFF, 1'b1, "R6 bad store");
    doOp(1'b1, 32'd96, 16'd6, 32'hFFFFFFFF, 1'b0, "R6 bad store2");
    doOp(1'b0, 32'd100, 16'd0, '0, 1'b1, "R6 after bad store");
    check(loadWord == 32'h01020304, "R6 untouched", loadWord, 32'h01020304);
    doOp(1'b0, 32'd103, 16'd0, '0, 1'b1, "R6 bad load");
    check(loadWord == 32'h0, "R6 zero", loadWord, 32'h0);

    // R8 hold across idle and store
    doOp(1'b0, 32'd100, 16'd0, '0, 1'b1, "R8 reload");
    idle("R8");
    doOp(1'b1, 32'd300, 16'd0, 32'h12345678, 1'b1, "R8 store keeps load");
    idle("R9");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] b, d;
      logic [15:0] o;
      bit st, be;
      b  = $urandom_range(0, 2 * DEPTH);
      o  = 16'($signed($urandom_range(0, 2 * DEPTH)) - DEPTH);
      if ($urandom_range(0, 7) != 0) o[1:0] = 2'b00 - b[1:0];
      d  = $urandom;
      st = $urandom_range(0, 1) == 1;
      be = $urandom_range(0, 1) == 1;
      doOp(st, b, o, d, be, "RND R2/R3/R4/R5/R7");
      if ($urandom_range(0, 5) == 0) idle("RND");
    end

    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end

endmodule